// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Generator with Command Port

This block drives a bank of independent pulse-width outputs from one shared tick enable. Each channel owns a down-counter and two reload registers, one for the high dwell and one for the low dwell. On every tick each counter counts down. When a counter is already at zero, the channel flips its level instead and reloads for the phase it has just entered. Changing the reload registers therefore changes the waveform without any per-cycle work from the host.

A host steers the bank through a small command port. A command carries a code and three arguments. The port is sampled only on tick cycles, and at most one command is taken per tick. The command takes effect after that tick's counter sweep, and a one-cycle done pulse acknowledges it. Five actions are available: program a channel's dwell times, switch its output driver on or off, pin its level high or low, realign one channel's counter to another channel's counter plus an offset, or do nothing for an unknown code. The block produces a level word and an output-enable word, with bit i belonging to channel i.

Top module: `pwm_bank`

## Requirements
- R1: Channel state changes only on a cycle where `tick` is high. On such a cycle, a counter above zero decrements, and a counter at zero makes the channel invert its internal level.
- R2: When a channel enters the high level it reloads its counter from the on register, and when it enters the low level it reloads from the off register. A channel programmed with N high ticks and M low ticks repeats a pattern of N high and M low ticks.
- R3: Code 1 (load) with arg0 = channel, arg1 = high ticks and arg2 = low ticks, both nonzero, stores arg1-1 and arg2-1, selects normal duty mode and enables the channel's output.
- R4: A load with a zero argument leaves both dwell registers unchanged. Zero high ticks selects forced-low with the output enabled, zero low ticks selects forced-high with the output enabled, and both zero only disables the output.
- R5: Code 3 (duty) writes arg1[1:0] as the channel's duty mode: 1 holds the output high, 2 holds it low, and 0 or 3 lets it follow the internal level.
- R6: The counter and internal level keep running while a level is forced. Returning to normal mode shows the internal level at once.
- R7: Code 2 (pin) sets the channel's output-enable bit to arg1[0]. A disabled channel has its enable bit and its level bit both at 0.
- R8: Code 4 (sync) writes the counter of channel arg1 with the counter of channel arg0, as it stands after this tick's sweep, plus arg2.
- R9: A command is accepted only on a cycle with both `tick` and `cmd_valid` high. `cmd_done` is high for exactly the one cycle that follows acceptance. An unknown code changes nothing and is still acknowledged.
- R10: Reset clears every counter, dwell register, level and enable and sets every duty mode to 0, so both output words read 0.
- R11: Bit i of `pwm_out` and of `pwm_oe` belongs to channel i, and a command addressed to one channel leaves every other bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Shared count enable for all channels |
| cmd_valid | input | 1 | Command request |
| cmd_code | input | 3 | Command code: 1 load, 2 pin, 3 duty, 4 sync |
| cmd_arg0 | input | CNT_W | Target channel (source channel for sync) |
| cmd_arg1 | input | CNT_W | High ticks, enable bit, duty mode, or sync destination channel |
| cmd_arg2 | input | CNT_W | Low ticks or sync offset |
| cmd_done | output | 1 | One-cycle acknowledge |
| pwm_out | output | NUM_CH | Output level per channel |
| pwm_oe | output | NUM_CH | Output enable per channel |

## Verification
The bench builds the block with 8 channels and 8-bit counters. A 3-tick high / 2-tick low pattern then repeats often enough for every check to land within a few dozen ticks. With only 8 channels, the bench can compare whole output words and catch any stray bit. The bench also relies on the reset counters all sitting at zero, which makes untouched channels toggle in lockstep. From that known starting phase, the sync test can predict which ticks see equal levels on two realigned channels, so a dropped or misapplied offset shows up at the outputs.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_LOAD = 3'd1,
    CMD_PIN  = 3'd2,
    CMD_DUTY = 3'd3,
    CMD_SYNC = 3'd4
  } cmd_e;

  localparam logic [1:0] DUTY_RUN  = 2'd0;
  localparam logic [1:0] DUTY_HIGH = 2'd1;
  localparam logic [1:0] DUTY_LOW  = 2'd2;

endpackage

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             times_we,
  input  logic [CNT_W-1:0] on_in,
  input  logic [CNT_W-1:0] off_in,
  input  logic             mode_we,
  input  logic [1:0]       mode_in,
  input  logic             oe_we,
  input  logic             oe_in,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_in,
  output logic [CNT_W-1:0] cnt_next,
  output logic             lvl,
  output logic             oe,
  output logic             force_hi,
  output logic             force_lo
);

  logic [CNT_W-1:0] cnt_q, on_q, off_q;
  logic [1:0]       mode_q;
  logic             lvl_q, oe_q;
  logic             underflow;

  // Counter value after one tick: reload for the phase being entered
  // (old level low -> entering high -> on register), else count down.
  function automatic logic [CNT_W-1:0] step_count(
    input logic [CNT_W-1:0] cur,
    input logic             old_lvl,
    input logic [CNT_W-1:0] hi_dwell,
    input logic [CNT_W-1:0] lo_dwell
  );
    if (cur == '0) return old_lvl ? lo_dwell : hi_dwell;
    return cur - 1'b1;
  endfunction

  assign underflow = tick && (cnt_q == '0);
  assign cnt_next  = tick ? step_count(cnt_q, lvl_q, on_q, off_q) : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      on_q   <= '0;
      off_q  <= '0;
      mode_q <= DUTY_RUN;
      lvl_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_next;
      if (underflow) lvl_q <= ~lvl_q;
      // command writes land after the sweep
      if (cnt_we) cnt_q <= cnt_in;
      if (times_we) begin
        on_q  <= on_in;
        off_q <= off_in;
      end
      if (mode_we) mode_q <= mode_in;
      if (oe_we)   oe_q   <= oe_in;
    end
  end

  assign lvl      = lvl_q;
  assign oe       = oe_q;
  assign force_hi = (mode_q == DUTY_HIGH);
  assign force_lo = (mode_q == DUTY_LOW);

endmodule

// File: rtl/pwm_cmd_dec.sv
module pwm_cmd_dec
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int CNT_W  = 32
) (
  input  logic              accept,
  input  logic [2:0]        code,
  input  logic [CNT_W-1:0]  arg0,
  input  logic [CNT_W-1:0]  arg1,
  input  logic [CNT_W-1:0]  arg2,
  input  logic [CNT_W-1:0]  src_cnt,
  output logic [NUM_CH-1:0] times_we,
  output logic [NUM_CH-1:0] mode_we,
  output logic [NUM_CH-1:0] oe_we,
  output logic [NUM_CH-1:0] cnt_we,
  output logic [CNT_W-1:0]  on_val,
  output logic [CNT_W-1:0]  off_val,
  output logic [1:0]        mode_val,
  output logic              oe_val,
  output logic [CNT_W-1:0]  cnt_val
);

  logic [NUM_CH-1:0] sel_a, sel_b;
  logic              on_zero, off_zero;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign sel_a[i] = (arg0 == CNT_W'(i));
    assign sel_b[i] = (arg1 == CNT_W'(i));
  end

  assign on_zero  = (arg1 == '0);
  assign off_zero = (arg2 == '0);
  assign on_val   = arg1 - 1'b1;
  assign off_val  = arg2 - 1'b1;
  assign cnt_val  = src_cnt + arg2;

  always_comb begin
    times_we = '0;
    mode_we  = '0;
    oe_we    = '0;
    cnt_we   = '0;
    mode_val = DUTY_RUN;
    oe_val   = 1'b0;
    if (accept) begin
      case (cmd_e'(code))
        CMD_LOAD: begin
          oe_we  = sel_a;
          oe_val = !(on_zero && off_zero);
          if (!on_zero && !off_zero) begin
            times_we = sel_a;
            mode_we  = sel_a;
            mode_val = DUTY_RUN;
          end else if (on_zero && !off_zero) begin
            mode_we  = sel_a;
            mode_val = DUTY_LOW;
          end else if (off_zero && !on_zero) begin
            mode_we  = sel_a;
            mode_val = DUTY_HIGH;
          end
        end
        CMD_PIN: begin
          oe_we  = sel_a;
          oe_val = arg1[0];
        end
        CMD_DUTY: begin
          mode_we  = sel_a;
          mode_val = arg1[1:0];
        end
        CMD_SYNC: cnt_we = sel_b;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_code,
  input  logic [CNT_W-1:0]  cmd_arg0,
  input  logic [CNT_W-1:0]  cmd_arg1,
  input  logic [CNT_W-1:0]  cmd_arg2,
  output logic              cmd_done,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] pwm_oe
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              cmd_accept;
  logic              done_q;
  logic [NUM_CH-1:0] times_we, mode_we, oe_we, cnt_we;
  logic [CNT_W-1:0]  on_val, off_val, cnt_val, src_cnt;
  logic [1:0]        mode_val;
  logic              oe_val;
  logic [NUM_CH-1:0] lvl_vec, force_hi_vec, force_lo_vec;
  logic [CNT_W-1:0]  cnt_next_arr [NUM_CH];

  // one command per sweep; the done cycle blocks a repeat of the same request
  assign cmd_accept = tick && cmd_valid && !done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= cmd_accept;
  end
  assign cmd_done = done_q;

  assign src_cnt = (cmd_arg0 < CNT_W'(NUM_CH)) ? cnt_next_arr[cmd_arg0[CH_W-1:0]] : '0;

  pwm_cmd_dec #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dec (
    .accept   (cmd_accept),
    .code     (cmd_code),
    .arg0     (cmd_arg0),
    .arg1     (cmd_arg1),
    .arg2     (cmd_arg2),
    .src_cnt  (src_cnt),
    .times_we (times_we),
    .mode_we  (mode_we),
    .oe_we    (oe_we),
    .cnt_we   (cnt_we),
    .on_val   (on_val),
    .off_val  (off_val),
    .mode_val (mode_val),
    .oe_val   (oe_val),
    .cnt_val  (cnt_val)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .times_we (times_we[i]),
      .on_in    (on_val),
      .off_in   (off_val),
      .mode_we  (mode_we[i]),
      .mode_in  (mode_val),
      .oe_we    (oe_we[i]),
      .oe_in    (oe_val),
      .cnt_we   (cnt_we[i]),
      .cnt_in   (cnt_val),
      .cnt_next (cnt_next_arr[i]),
      .lvl      (lvl_vec[i]),
      .oe       (pwm_oe[i]),
      .force_hi (force_hi_vec[i]),
      .force_lo (force_lo_vec[i])
    );
    assign pwm_out[i] = pwm_oe[i] &&
                        (force_hi_vec[i] || (!force_lo_vec[i] && lvl_vec[i]));
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NUM_CH = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              accept,
  input logic              cmd_done,
  input logic [NUM_CH-1:0] lvl_vec,
  input logic [NUM_CH-1:0] force_hi,
  input logic [NUM_CH-1:0] force_lo,
  input logic [NUM_CH-1:0] pwm_out,
  input logic [NUM_CH-1:0] pwm_oe
);

  assert_lvl_tick_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(lvl_vec));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  assert_done_follows_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> $past(accept));

  assert_accept_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> tick);

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out & ~pwm_oe) == '0);

  assert_forced_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (force_hi & pwm_oe & ~pwm_out) == '0);

  assert_forced_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (force_lo & pwm_out) == '0);

endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .accept   (cmd_accept),
  .cmd_done (cmd_done),
  .lvl_vec  (lvl_vec),
  .force_hi (force_hi_vec),
  .force_lo (force_lo_vec),
  .pwm_out  (pwm_out),
  .pwm_oe   (pwm_oe)
);

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NCH = 8;
  localparam int CW  = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tick = 1'b0;
  logic           cmd_valid = 1'b0;
  logic [2:0]     cmd_code = '0;
  logic [CW-1:0]  cmd_arg0 = '0, cmd_arg1 = '0, cmd_arg2 = '0;
  logic           cmd_done;
  logic [NCH-1:0] pwm_out, pwm_oe;

  int n_checks = 0;
  int n_fail   = 0;

  // bench view of channel 2
  int k2 = 0;      // ticks since channel 2 was loaded with 3 high / 2 low
  bit en2 = 0;
  int m2 = 0;      // 0 follow, 1 high, 2 low

  always #2.5 clk = ~clk;

  pwm_bank #(.NUM_CH(NCH), .CNT_W(CW)) u_pwm_bank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_arg0(cmd_arg0), .cmd_arg1(cmd_arg1),
    .cmd_arg2(cmd_arg2), .cmd_done(cmd_done), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit run_lvl(input int k);
    if (k == 0) return 1'b1;
    return ((k - 1) % 5) >= 2;
  endfunction

  function automatic bit exp_ch2();
    if (!en2) return 1'b0;
    if (m2 == 1) return 1'b1;
    if (m2 == 2) return 1'b0;
    return run_lvl(k2);
  endfunction

  task automatic check_ch2(input string req);
    check(pwm_out[2] == exp_ch2(), req, int'(pwm_out[2]), int'(exp_ch2()));
    check(pwm_oe[2] == en2, req, int'(pwm_oe[2]), int'(en2));
  endtask

  task automatic one_tick();
    tick = 1'b1;
    @(posedge clk); @(negedge clk);
    tick = 1'b0;
    k2++;
  endtask

  task automatic send_cmd(input int code, input int a0, input int a1, input int a2);
    cmd_code = code[2:0]; cmd_arg0 = a0[CW-1:0]; cmd_arg1 = a1[CW-1:0]; cmd_arg2 = a2[CW-1:0];
    cmd_valid = 1'b1; tick = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; tick = 1'b0;
    k2++;
    check(cmd_done == 1'b1, "R9 done after accept", int'(cmd_done), 1);
    @(posedge clk); @(negedge clk);
    check(cmd_done == 1'b0, "R9 done one cycle", int'(cmd_done), 0);
  endtask

  task automatic t_reset();
    check(pwm_out == '0, "R10 out after reset", int'(pwm_out), 0);
    check(pwm_oe == '0, "R10 oe after reset", int'(pwm_oe), 0);
    check(cmd_done == 1'b0, "R10 done after reset", int'(cmd_done), 0);
  endtask

  task automatic t_load_run();
    send_cmd(1, 2, 3, 2);            // R3 load 3 high / 2 low
    k2 = 0; en2 = 1; m2 = 0;
    check(pwm_oe == 8'h04, "R11 only channel 2 enabled", int'(pwm_oe), 4);
    check_ch2("R3 level after load");
    for (int i = 0; i < 10; i++) begin
      one_tick();
      check_ch2("R2 dwell pattern");
      check((pwm_out & 8'hFB) == '0, "R11 other bits quiet", int'(pwm_out), 0);
    end
  endtask

  task automatic t_tick_gate();
    logic [NCH-1:0] held;
    held = pwm_out;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); @(negedge clk);
      check(pwm_out == held, "R1 no change without tick", int'(pwm_out), int'(held));
    end
    for (int i = 0; i < 3; i++) begin
      one_tick();
      check_ch2("R1 resumes on tick");
    end
  endtask

  task automatic t_zero_load();
    send_cmd(1, 2, 0, 5); m2 = 2;    // R4 zero high ticks
    check_ch2("R4 forced low");
    for (int i = 0; i < 4; i++) begin one_tick(); check_ch2("R4 forced low held"); end
    send_cmd(1, 2, 4, 0); m2 = 1;    // R4 zero low ticks
    for (int i = 0; i < 4; i++) begin one_tick(); check_ch2("R4 forced high held"); end
    send_cmd(1, 2, 0, 0); en2 = 0;   // R4 both zero
    check_ch2("R4 both zero disables");
    send_cmd(2, 2, 1, 0); en2 = 1;   // R7 enable again, mode stays high
    check_ch2("R7 re-enable keeps forced high");
    send_cmd(3, 2, 0, 0); m2 = 0;    // R6 back to follow, dwell unchanged
    for (int i = 0; i < 7; i++) begin one_tick(); check_ch2("R6 R4 pattern kept"); end
  endtask

  task automatic t_duty();
    send_cmd(3, 2, 2, 0); m2 = 2;
    for (int i = 0; i < 3; i++) begin one_tick(); check_ch2("R5 mode 2 low"); end
    send_cmd(3, 2, 3, 0); m2 = 0;    // R5 code 3 follows level
    for (int i = 0; i < 5; i++) begin one_tick(); check_ch2("R5 mode 3 follows"); end
    send_cmd(2, 2, 2, 0); en2 = 0;   // R7 bit0 = 0 disables
    check_ch2("R7 disable by bit0");
    one_tick(); check_ch2("R7 disabled stays quiet");
    send_cmd(2, 2, 3, 0); en2 = 1;
    check_ch2("R7 enable by bit0");
  endtask

  task automatic t_handshake();
    logic [NCH-1:0] oe_before;
    oe_before = pwm_oe;
    cmd_code = 3'd7; cmd_arg0 = 8'd2; cmd_arg1 = '0; cmd_arg2 = '0;
    cmd_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      check(cmd_done == 1'b0, "R9 no accept without tick", int'(cmd_done), 0);
    end
    tick = 1'b1;
    @(posedge clk); @(negedge clk);
    tick = 1'b0; cmd_valid = 1'b0; k2++;
    check(cmd_done == 1'b1, "R9 unknown code acknowledged", int'(cmd_done), 1);
    @(posedge clk); @(negedge clk);
    check(cmd_done == 1'b0, "R9 done one cycle", int'(cmd_done), 0);
    check(pwm_oe == oe_before, "R9 unknown code no effect", int'(pwm_oe), int'(oe_before));
    check_ch2("R9 unknown code keeps pattern");
  endtask

  task automatic t_phase();
    int eq;
    send_cmd(1, 5, 4, 4);
    send_cmd(1, 6, 4, 4);
    send_cmd(4, 5, 6, 1);            // R8 ch6 := ch5 + 1
    check(pwm_oe == 8'h64, "R11 enables 2,5,6", int'(pwm_oe), 8'h64);
    eq = 0;
    for (int i = 0; i < 8; i++) begin
      one_tick();
      if (pwm_out[5] == pwm_out[6]) eq++;
    end
    check(eq == 2, "R8 sync offset ticks equal", eq, 2);
    check_ch2("R11 channel 2 unaffected by sync");
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    #(5.0 * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    t_reset();
    t_load_run();
    t_tick_gate();
    t_zero_load();
    t_duty();
    t_handshake();
    t_phase();
    report();
    $finish;
  end

endmodule